// File: doc/BRIEF.md
# DAC Data Update Scheduler

This block sits between a byte-wide register bus and a 10-bit current-output converter. Software writes a control byte and two data bytes. The data bytes are kept in holding registers, and they reach the converter only when a trigger picked by the control byte fires. The trigger is one of four timer-overflow pulses, or an edge of an external strobe. Because the update is tied to that event, the sample timing does not depend on when the write arrives. A fifth mode updates right after the high byte is written.

The bus write port is valid/ready. Ready is held high at all times, so a write is taken in every cycle its valid is high and the port never applies back-pressure. Reads are combinational from a separate address. Two synchronous active-low resets are provided. The system reset can spare the control byte and the output latch when the persist bit is set. The power-on reset, which also covers the supply monitor, always clears everything. The full-scale range field is passed straight out as a code. Output current is code/1024 of full scale: 0.5 mA for 00, 1 mA for 01, 2 mA for 1x.

Top module: `dac_update_sched`

## Requirements
- R1: `wr_ready` is always 1 and a write is taken on any clock edge with `wr_valid` high. Address 0 is control, 1 is high data, 2 is low data, and address 3 writes are dropped. `rd_data` returns the addressed register. Control bit 3 reads 0. The low register reads its bits 7:6 with bits 5:0 as zero.
- R2: Control bits [6:4] give the mode. Codes 0 to 3 load the output latch on the clock edge where `timer_ovf[code]` is high.
- R3: Mode 4 loads on a rising strobe edge, mode 5 on a falling edge and mode 6 on either edge. An edge is seen at the first clock edge where `strobe` differs from its value at the previous clock edge. An edge of the wrong direction does not load.
- R4: In all modes, data writes alone leave `dac_code` unchanged until the trigger fires. The latest written values are the ones loaded. A trigger on the same edge as a write loads the older value.
- R5: The loaded code is {high[7:0], low[7:6]}.
- R6: Mode 7 loads the latch one clock edge after the edge that takes a high-register write. Low writes alone do not load.
- R7: A system reset (`rst_n` low at an edge) with control bit 2 (persist) at 0 sets control to 0x02 and clears `dac_code` and `dac_en`.
- R8: A system reset with persist at 1 leaves control, `dac_en` and `dac_code` unchanged. The holding registers are cleared in both cases.
- R9: A power-on reset (`por_n` low at an edge) sets control to 0x02 and clears `dac_code` and `dac_en`, whatever the persist bit holds.
- R10: `dac_en` follows control bit 7 and `range_code` follows control bits [1:0]. After reset `range_code` is 2'b10, the 2 mA setting.
- R11: In a timer mode, overflow pulses on timers that are not selected do not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on/supply reset, synchronous, active low |
| rst_n | input | 1 | System reset, synchronous, active low |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted, always 1 |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data byte |
| timer_ovf | input | N_TMR | Timer overflow pulses |
| strobe | input | 1 | Synchronised external conversion strobe |
| dac_en | output | 1 | Converter enable |
| dac_code | output | 10 | Latched converter code |
| range_code | output | 2 | Full-scale range select |

## Verification
A wrong trigger decode shows at the next edge as a `dac_code` that changes after a write or a stray pulse, or that stays put after the selected event. A wrong reset path shows in the first cycle after the reset. The control read-back, `dac_en` or `dac_code` then either keeps a value that should be cleared or loses one that should persist. A wrong bit mapping gives a wrong code on the first load, so the bench compares the exact code after every trigger.

// File: rtl/dac_sched_pkg.sv
package dac_sched_pkg;
  localparam int BUS_W = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;
  localparam int CTRL_EN      = 7;
  localparam int CTRL_PERSIST = 2;
  localparam logic [BUS_W-1:0] CTRL_RST  = 8'h02;
  localparam logic [BUS_W-1:0] CTRL_MASK = 8'hF7;
  typedef enum logic [2:0] {
    M_TMR0 = 3'd0, M_TMR1 = 3'd1, M_TMR2 = 3'd2, M_TMR3 = 3'd3,
    M_RISE = 3'd4, M_FALL = 3'd5, M_BOTH = 3'd6, M_ONWR = 3'd7
  } upd_mode_e;
endpackage

// File: rtl/dac_sched_regs.sv
module dac_sched_regs
  import dac_sched_pkg::*;
#(
  parameter int LSB_W = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic [BUS_W-1:0] ctrl_q,
  output logic [BUS_W-1:0] hi_q,
  output logic [LSB_W-1:0] lo_q,
  output logic             hi_wr
);
  localparam int PAD_W = BUS_W - LSB_W;

  logic wr_ctrl, wr_hi, wr_lo;
  assign wr_ctrl = wr_valid && (wr_addr == ADDR_CTRL);
  assign wr_hi   = wr_valid && (wr_addr == ADDR_HI);
  assign wr_lo   = wr_valid && (wr_addr == ADDR_LO);
  assign hi_wr   = wr_hi;

  always_ff @(posedge clk) begin
    if (!por_n || (!rst_n && !ctrl_q[CTRL_PERSIST])) ctrl_q <= CTRL_RST;
    else if (rst_n && wr_ctrl)                          ctrl_q <= wr_data & CTRL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi) hi_q <= wr_data;
      if (wr_lo) lo_q <= wr_data[BUS_W-1 -: LSB_W];
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = ctrl_q;
      ADDR_HI:   rd_data = hi_q;
      ADDR_LO:   rd_data = {lo_q, {PAD_W{1'b0}}};
      default:   rd_data = '0;
    endcase
  end

  assert_por_clear_R9: assert property (@(posedge clk) !por_n |=> (ctrl_q == CTRL_RST));
  assert_ctrl_persist_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && ctrl_q[CTRL_PERSIST]) |=> $stable(ctrl_q));
  assert_ctrl_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !ctrl_q[CTRL_PERSIST]) |=> (ctrl_q == CTRL_RST));
endmodule

// File: rtl/dac_sched_trig.sv
module dac_sched_trig
  import dac_sched_pkg::*;
#(
  parameter int N_TMR = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [N_TMR-1:0] timer_ovf,
  input  logic             strobe,
  input  logic             hi_wr,
  output logic             load
);
  logic strobe_d, hi_wr_q;
  logic [N_TMR-1:0] tmr_hit;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      strobe_d <= strobe;
      hi_wr_q  <= 1'b0;
    end else begin
      strobe_d <= strobe;
      hi_wr_q  <= hi_wr;
    end
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    assign tmr_hit[i] = timer_ovf[i] && (mode == 3'(i));
    assert_tmr_fire_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (mode == 3'(i) && timer_ovf[i]) |-> load);
  end

  always_comb begin
    case (upd_mode_e'(mode))
      M_RISE:  load = strobe && !strobe_d;
      M_FALL:  load = !strobe && strobe_d;
      M_BOTH:  load = strobe ^ strobe_d;
      M_ONWR:  load = hi_wr_q;
      default: load = |tmr_hit;
    endcase
  end

  assert_rise_fire_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (mode == M_RISE && $rose(strobe)) |-> load);
  assert_fall_fire_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (mode == M_FALL && $fell(strobe)) |-> load);
  assert_quiet_strobe_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (mode inside {M_RISE, M_FALL, M_BOTH} && $stable(strobe)) |-> !load);
endmodule

// File: rtl/dac_sched_latch.sv
module dac_sched_latch
  import dac_sched_pkg::*;
#(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             persist,
  input  logic             load,
  input  logic [DAC_W-1:0] word,
  output logic [DAC_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (!por_n || (!rst_n && !persist)) code_q <= '0;
    else if (rst_n && load)             code_q <= word;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && !load) |=> $stable(code_q));
  assert_load_R5: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && load) |=> (code_q == $past(word)));
  assert_keep_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && persist) |=> $stable(code_q));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !persist) |=> (code_q == '0));
endmodule

// File: rtl/dac_update_sched.sv
module dac_update_sched
  import dac_sched_pkg::*;
#(
  parameter int N_TMR = 4,
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  input  logic [N_TMR-1:0] timer_ovf,
  input  logic             strobe,
  output logic             dac_en,
  output logic [DAC_W-1:0] dac_code,
  output logic [1:0]       range_code
);
  localparam int LSB_W = DAC_W - BUS_W;

  logic [BUS_W-1:0] ctrl_q, hi_q;
  logic [LSB_W-1:0] lo_q;
  logic             hi_wr, load;

  assign wr_ready   = 1'b1;
  assign dac_en     = ctrl_q[CTRL_EN];
  assign range_code = ctrl_q[1:0];

  dac_sched_regs #(.LSB_W(LSB_W)) u_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_q(ctrl_q), .hi_q(hi_q), .lo_q(lo_q), .hi_wr(hi_wr)
  );

  dac_sched_trig #(.N_TMR(N_TMR)) u_trig (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .mode(ctrl_q[6:4]), .timer_ovf(timer_ovf), .strobe(strobe),
    .hi_wr(hi_wr), .load(load)
  );

  dac_sched_latch #(.DAC_W(DAC_W)) u_latch (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .persist(ctrl_q[CTRL_PERSIST]), .load(load),
    .word({hi_q, lo_q}), .code_q(dac_code)
  );

  assert_en_por_R9: assert property (@(posedge clk) !por_n |=> (!dac_en && dac_code == '0));
endmodule

// File: tb/dac_update_sched_tb.sv
module dac_update_sched_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n, rst_n, wr_valid, wr_ready, strobe, dac_en;
  logic [1:0] wr_addr, rd_addr, range_code;
  logic [7:0] wr_data, rd_data;
  logic [3:0] timer_ovf;
  logic [9:0] dac_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // vector: mode[31:29] hi[28:21] lo[20:13] trig[12:10] exp[9:0]; trig 0-3 timer, 4 strobe up, 5 strobe down
  localparam logic [31:0] VECS [8] = '{
    {3'd0, 8'hA5, 8'hC0, 3'd0, 10'h297},
    {3'd1, 8'h3C, 8'h40, 3'd1, 10'h0F1},
    {3'd2, 8'hFF, 8'hFF, 3'd2, 10'h3FF},
    {3'd3, 8'h00, 8'h80, 3'd3, 10'h002},
    {3'd4, 8'h80, 8'h00, 3'd4, 10'h200},
    {3'd5, 8'h12, 8'h7F, 3'd5, 10'h049},
    {3'd6, 8'h01, 8'h3F, 3'd4, 10'h004},
    {3'd6, 8'h55, 8'hC0, 3'd5, 10'h157}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_update_sched u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .timer_ovf(timer_ovf), .strobe(strobe),
    .dac_en(dac_en), .dac_code(dac_code), .range_code(range_code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic pulse_timer(input int idx);
    @(negedge clk);
    timer_ovf = '0; timer_ovf[idx] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    timer_ovf = '0;
  endtask

  task automatic set_strobe(input logic v);
    @(negedge clk);
    strobe = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire(input int t);
    if (t < 4) pulse_timer(t);
    else set_strobe(t == 4);
  endtask

  task automatic pulse_rst(input bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [9:0] prev;
    por_n = 0; rst_n = 0; wr_valid = 0; wr_addr = 0; wr_data = 0;
    rd_addr = 0; timer_ovf = 0; strobe = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_n = 1; rst_n = 1;

    // reset state: R1, R9, R10
    check("R9 reset code", dac_code, 0);
    check("R9 reset en", dac_en, 0);
    check("R10 reset range", range_code, 2'b10);
    check("R1 ready", wr_ready, 1);
    read_chk("R9 reset ctrl", 2'd0, 8'h02);

    // table walk: R2 R3 R4 R5 R11
    prev = '0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = VECS[i];
      bus_write(2'd0, {1'b1, v[31:29], 4'b0010});
      bus_write(2'd1, v[28:21]);
      bus_write(2'd2, v[20:13]);
      check("R4 held after writes", dac_code, prev);
      if (v[12:10] < 3'd4) begin
        pulse_timer((int'(v[12:10]) + 1) % 4);
        check("R11 other timer ignored", dac_code, prev);
      end
      fire(int'(v[12:10]));
      check("R2/R3/R5 triggered load", dac_code, v[9:0]);
      prev = v[9:0];
    end

    // R1: read-back, low-register padding, address 3 ignored
    bus_write(2'd3, 8'hFF);
    read_chk("R1 ctrl readback", 2'd0, 8'hE2);
    read_chk("R1 hi readback", 2'd1, 8'h55);
    read_chk("R1 lo readback", 2'd2, 8'hC0);
    bus_write(2'd2, 8'h7F);
    read_chk("R1 lo bits 5:0 zero", 2'd2, 8'h40);

    // R4: latest write wins
    bus_write(2'd0, 8'h82);
    bus_write(2'd1, 8'h11);
    bus_write(2'd1, 8'h22);
    bus_write(2'd2, 8'h00);
    pulse_timer(0);
    check("R4 latest wins", dac_code, 10'h088);

    // R3: wrong edge ignored in falling mode
    bus_write(2'd0, 8'hD2);
    bus_write(2'd1, 8'hAA);
    set_strobe(1'b1);
    check("R3 rise ignored in fall mode", dac_code, 10'h088);
    set_strobe(1'b0);
    check("R3 fall loads", dac_code, 10'h2A8);

    // R6: load on high write
    bus_write(2'd0, 8'hF2);
    bus_write(2'd2, 8'hC0);
    check("R6 low write no load", dac_code, 10'h2A8);
    bus_write(2'd1, 8'h0F);
    check("R6 not yet loaded", dac_code, 10'h2A8);
    @(negedge clk);
    check("R6 loaded next edge", dac_code, 10'h03F);

    // R10: range field
    bus_write(2'd0, 8'h80);
    check("R10 range 00", range_code, 2'b00);
    bus_write(2'd0, 8'h81);
    check("R10 range 01", range_code, 2'b01);
    bus_write(2'd0, 8'h03);
    check("R10 range 11", range_code, 2'b11);
    check("R10 en off", dac_en, 0);

    // R8: persist across system reset
    bus_write(2'd0, 8'h86);
    bus_write(2'd1, 8'h66);
    bus_write(2'd2, 8'h40);
    pulse_timer(0);
    check("R5 load", dac_code, 10'h199);
    pulse_rst(0);
    check("R8 code kept", dac_code, 10'h199);
    check("R8 en kept", dac_en, 1);
    read_chk("R8 ctrl kept", 2'd0, 8'h86);
    read_chk("R8 hi cleared", 2'd1, 8'h00);

    // R7: system reset without persist
    bus_write(2'd0, 8'h82);
    pulse_rst(0);
    check("R7 code cleared", dac_code, 0);
    check("R7 en cleared", dac_en, 0);
    read_chk("R7 ctrl reset", 2'd0, 8'h02);

    // R9: power-on reset overrides persist
    bus_write(2'd0, 8'h86);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hC0);
    pulse_timer(0);
    check("R5 full scale", dac_code, 10'h3FF);
    pulse_rst(1);
    check("R9 code cleared", dac_code, 0);
    check("R9 en cleared", dac_en, 0);
    read_chk("R9 ctrl reset", 2'd0, 8'h02);
    check("R10 range after por", range_code, 2'b10);

    finish_run();
  end
endmodule